// File: doc/BRIEF.md
# Sensor Edge Position Capture Unit

This block watches three digital sensor lines next to a moving mechanism: an upper presence sensor, a lower presence sensor and a hall sensor. When a chosen transition appears on one of them, it records the current value of a signed position count that another block supplies. It also advances an event counter that belongs to that transition. The sensor lines arrive already synchronised to the clock. The position value is taken as it stands in the cycle the edge is seen.

The lower sensor's falling transition is handled differently. It does not record the position at once. Instead it arms a delay that is measured in millisecond tick strobes, and the position is recorded when that delay runs out. This lets the mechanism settle before its position is taken. A second falling transition that arrives while the delay is armed restarts the wait.

All counters and captured positions live in a working set. A reader sees them only through a shadow copy, which is refreshed from the working set by a single-cycle snapshot strobe. Every value the reader sees was therefore taken at the same instant.

Top module: `edge_pos_capture`

## Requirements
- R1: A rising transition on `upper_in` adds one to the upper-rise count and records `position` as the upper-rise capture.
- R2: A falling transition on `upper_in` adds one to the upper-fall count and records `position` as the upper-fall capture. The upper-rise values are left untouched.
- R3: A rising transition on `lower_in` adds one to the lower-rise count only. No capture output changes.
- R4: A falling transition on `lower_in` adds one to the lower-fall count and arms a delay of `DELAY_TICKS` tick strobes. On the `DELAY_TICKS`-th `ms_tick` after the edge, `position` is recorded as the delayed capture and the delayed count adds one. No capture takes place before that tick.
- R5: A falling transition on `lower_in` that arrives while the delay is armed restarts the tick count from zero. Exactly one delayed capture results. Further ticks after the capture have no effect.
- R6: With `HALL_RISE` = 0 (the default), a falling transition on `hall_in` adds one to the hall count and records `position` as the hall capture. A rising transition on `hall_in` changes neither value. With `HALL_RISE` = 1 the polarities swap.
- R7: Every event count is 8 bits wide and wraps from 255 to 0. Only reset clears it.
- R8: Every output is a shadow register. A high `snapshot` copies all six counts and four captures into the shadow registers in one clock. The copy holds the working values from before any edge seen in that same cycle. While `snapshot` is low, no output changes.
- R9: Synchronous active-high `rst` clears all counts, captures and shadow registers, and disarms a pending delay. A falling edge seen before reset therefore yields no delayed capture afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upper_in | input | 1 | Upper presence sensor, synchronised |
| lower_in | input | 1 | Lower presence sensor, synchronised |
| hall_in | input | 1 | Hall sensor, synchronised |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| position | input | 32 | Signed position count to be recorded |
| snapshot | input | 1 | Copy working set into shadow registers |
| cap_upper_rise | output | 32 | Position at last upper rising edge |
| cap_upper_fall | output | 32 | Position at last upper falling edge |
| cap_lower_delayed | output | 32 | Position at end of last lower-fall delay |
| cap_hall | output | 32 | Position at last counted hall edge |
| cnt_upper_rise | output | 8 | Upper rising edge count |
| cnt_upper_fall | output | 8 | Upper falling edge count |
| cnt_lower_rise | output | 8 | Lower rising edge count |
| cnt_lower_fall | output | 8 | Lower falling edge count |
| cnt_delayed | output | 8 | Delayed capture count |
| cnt_hall | output | 8 | Hall edge count |

## Verification
The bench builds the block with `DELAY_TICKS` = 4 and keeps `HALL_RISE` at 0. The short delay makes it cheap to tick one short of expiry, to land exactly on expiry, and to restart the delay partway through. The default hall polarity lets the bench show that a rising hall transition is ignored. With 8-bit counts, a 256-event loop is enough to demonstrate the wrap.

// File: rtl/epc_pkg.sv
package epc_pkg;
    localparam int POS_W = 32;
    localparam int CNT_W = 8;
    localparam int NEV   = 6;

    // event slot indices
    localparam int EV_UP_RISE = 0;
    localparam int EV_UP_FALL = 1;
    localparam int EV_LO_RISE = 2;
    localparam int EV_LO_FALL = 3;
    localparam int EV_DELAYED = 4;
    localparam int EV_HALL    = 5;

    // slots that also record the position
    localparam logic [NEV-1:0] CAP_MASK = 6'b110011;

    typedef logic signed [POS_W-1:0] pos_t;
    typedef logic [CNT_W-1:0]        cnt_t;

    typedef struct packed {
        cnt_t [NEV-1:0] cnt;
        pos_t [NEV-1:0] cap;
    } view_t;

    function automatic cnt_t bump(input cnt_t c);
        return c + cnt_t'(1);
    endfunction
endpackage

// File: rtl/epc_edge_detect.sv
module epc_edge_detect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
    assign fall = ~lines & prev_q;
endmodule

// File: rtl/epc_delay_timer.sv
module epc_delay_timer #(
    parameter int DELAY_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic pending,
    output logic expire
);
    localparam int TW = $clog2(DELAY_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(DELAY_TICKS - 1);

    logic [TW-1:0] ticks_q;
    logic          pend_q;

    assign expire  = pend_q && tick && !start && (ticks_q == LAST);
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            ticks_q <= '0;
        end else if (start) begin
            pend_q  <= 1'b1;
            ticks_q <= '0;
        end else if (pend_q && tick) begin
            if (ticks_q == LAST) begin
                pend_q  <= 1'b0;
                ticks_q <= '0;
            end else begin
                ticks_q <= ticks_q + TW'(1);
            end
        end
    end
endmodule

// File: rtl/epc_capture_bank.sv
module epc_capture_bank
    import epc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] ev,
    input  pos_t           position,
    output cnt_t [NEV-1:0] cnt,
    output pos_t [NEV-1:0] cap
);
    for (genvar i = 0; i < NEV; i++) begin : g_slot
        cnt_t cnt_q;
        always_ff @(posedge clk) begin
            if (rst)        cnt_q <= '0;
            else if (ev[i]) cnt_q <= bump(cnt_q);
        end
        assign cnt[i] = cnt_q;

        if (CAP_MASK[i]) begin : g_cap
            pos_t cap_q;
            always_ff @(posedge clk) begin
                if (rst)        cap_q <= '0;
                else if (ev[i]) cap_q <= position;
            end
            assign cap[i] = cap_q;
        end else begin : g_nocap
            assign cap[i] = '0;
        end
    end
endmodule

// File: rtl/edge_pos_capture.sv
module edge_pos_capture
    import epc_pkg::*;
#(
    parameter int DELAY_TICKS = 32,
    parameter bit HALL_RISE   = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        upper_in,
    input  logic        lower_in,
    input  logic        hall_in,
    input  logic        ms_tick,
    input  logic [31:0] position,
    input  logic        snapshot,
    output logic [31:0] cap_upper_rise,
    output logic [31:0] cap_upper_fall,
    output logic [31:0] cap_lower_delayed,
    output logic [31:0] cap_hall,
    output logic [7:0]  cnt_upper_rise,
    output logic [7:0]  cnt_upper_fall,
    output logic [7:0]  cnt_lower_rise,
    output logic [7:0]  cnt_lower_fall,
    output logic [7:0]  cnt_delayed,
    output logic [7:0]  cnt_hall
);
    logic [2:0]     rise, fall;
    logic [NEV-1:0] ev;
    logic           dly_pending, dly_expire;
    cnt_t [NEV-1:0] live_cnt;
    pos_t [NEV-1:0] live_cap;
    view_t          shadow_q;

    epc_edge_detect #(.N(3)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lines({hall_in, lower_in, upper_in}),
        .rise (rise),
        .fall (fall)
    );

    epc_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .start  (fall[1]),
        .tick   (ms_tick),
        .pending(dly_pending),
        .expire (dly_expire)
    );

    assign ev[EV_UP_RISE] = rise[0];
    assign ev[EV_UP_FALL] = fall[0];
    assign ev[EV_LO_RISE] = rise[1];
    assign ev[EV_LO_FALL] = fall[1];
    assign ev[EV_DELAYED] = dly_expire;

    if (HALL_RISE) begin : g_hall_rise
        assign ev[EV_HALL] = rise[2];
    end else begin : g_hall_fall
        assign ev[EV_HALL] = fall[2];
    end

    epc_capture_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .position(pos_t'(position)),
        .cnt     (live_cnt),
        .cap     (live_cap)
    );

    always_ff @(posedge clk) begin
        if (rst)           shadow_q <= '0;
        else if (snapshot) shadow_q <= '{cnt: live_cnt, cap: live_cap};
    end

    assign cap_upper_rise    = shadow_q.cap[EV_UP_RISE];
    assign cap_upper_fall    = shadow_q.cap[EV_UP_FALL];
    assign cap_lower_delayed = shadow_q.cap[EV_DELAYED];
    assign cap_hall          = shadow_q.cap[EV_HALL];
    assign cnt_upper_rise    = shadow_q.cnt[EV_UP_RISE];
    assign cnt_upper_fall    = shadow_q.cnt[EV_UP_FALL];
    assign cnt_lower_rise    = shadow_q.cnt[EV_LO_RISE];
    assign cnt_lower_fall    = shadow_q.cnt[EV_LO_FALL];
    assign cnt_delayed       = shadow_q.cnt[EV_DELAYED];
    assign cnt_hall          = shadow_q.cnt[EV_HALL];
endmodule

// File: rtl/edge_pos_capture_chk.sv
module edge_pos_capture_chk
    import epc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           upper_in,
    input logic           lower_in,
    input logic [31:0]    position,
    input logic           snapshot,
    input logic [31:0]    cap_upper_rise,
    input logic [31:0]    cap_lower_delayed,
    input logic [7:0]     cnt_upper_rise,
    input logic [7:0]     cnt_hall,
    input logic           dly_pending,
    input cnt_t [NEV-1:0] live_cnt,
    input pos_t [NEV-1:0] live_cap
);
    // R1
    a_r1_rise_counts: assert property (@(posedge clk) disable iff (rst)
        $rose(upper_in) |=> live_cnt[EV_UP_RISE] == cnt_t'($past(live_cnt[EV_UP_RISE]) + 8'd1));

    // R2
    a_r2_fall_records: assert property (@(posedge clk) disable iff (rst)
        $fell(upper_in) |=> (live_cap[EV_UP_FALL] == pos_t'($past(position)))
                            && $stable(live_cap[EV_UP_RISE]));

    // R3
    a_r3_lower_rise_counts: assert property (@(posedge clk) disable iff (rst)
        $rose(lower_in) |=> live_cnt[EV_LO_RISE] == cnt_t'($past(live_cnt[EV_LO_RISE]) + 8'd1));

    // R4
    a_r4_fall_arms_delay: assert property (@(posedge clk) disable iff (rst)
        $fell(lower_in) |=> dly_pending);

    // R4, R5
    a_r4_no_capture_unarmed: assert property (@(posedge clk) disable iff (rst)
        !dly_pending |=> $stable(live_cnt[EV_DELAYED]) && $stable(live_cap[EV_DELAYED]));

    // R8
    a_r8_snapshot_copies: assert property (@(posedge clk) disable iff (rst)
        snapshot |=> (cnt_hall == $past(live_cnt[EV_HALL]))
                     && (cap_upper_rise == $past(live_cap[EV_UP_RISE])));

    // R8
    a_r8_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        !snapshot |=> $stable(cnt_upper_rise) && $stable(cap_lower_delayed));
endmodule

bind edge_pos_capture edge_pos_capture_chk u_chk (.*);

// File: tb/edge_pos_capture_bench.sv
`timescale 1ns/1ps
module edge_pos_capture_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upper_in = 1'b0, lower_in = 1'b0, hall_in = 1'b0, ms_tick = 1'b0;
    logic [31:0] position = '0;
    logic        snapshot = 1'b0;
    logic [31:0] cap_upper_rise, cap_upper_fall, cap_lower_delayed, cap_hall;
    logic [7:0]  cnt_upper_rise, cnt_upper_fall, cnt_lower_rise, cnt_lower_fall;
    logic [7:0]  cnt_delayed, cnt_hall;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    edge_pos_capture #(.DELAY_TICKS(4), .HALL_RISE(1'b0)) u_edge_pos_capture (.*);

    typedef struct packed {
        logic        up;
        logic        lo;
        logic [31:0] pos;
        logic [7:0]  e_ur, e_uf, e_lr, e_lf;
        logic [31:0] e_cur, e_cuf;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 32'd100,        8'd1, 8'd0, 8'd0, 8'd0, 32'd100, 32'd0},
        '{1'b1, 1'b1, 32'd200,        8'd1, 8'd0, 8'd1, 8'd0, 32'd100, 32'd0},
        '{1'b0, 1'b1, 32'hFFFF_FFFB,  8'd1, 8'd1, 8'd1, 8'd0, 32'd100, 32'hFFFF_FFFB},
        '{1'b1, 1'b0, 32'd7,          8'd2, 8'd1, 8'd1, 8'd1, 32'd7,   32'hFFFF_FFFB},
        '{1'b0, 1'b0, 32'h7FFF_FFFF,  8'd2, 8'd2, 8'd1, 8'd1, 32'd7,   32'h7FFF_FFFF},
        '{1'b0, 1'b1, 32'd3,          8'd2, 8'd2, 8'd2, 8'd1, 32'd7,   32'h7FFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic u, input logic l, input logic h, input logic t,
                         input logic [31:0] p);
        @(negedge clk);
        upper_in = u; lower_in = l; hall_in = h; ms_tick = t; position = p;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk);
        snapshot = 1'b1;
        @(negedge clk);
        snapshot = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upper_in = 0; lower_in = 0; hall_in = 0; ms_tick = 0; snapshot = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tick(input logic [31:0] p);
        apply(upper_in, lower_in, hall_in, 1'b1, p);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] ur0, uf0;
        do_reset();
        snap();
        // R9: reset state
        check("R9 cnt_upper_rise", cnt_upper_rise, 0);
        check("R9 cnt_delayed", cnt_delayed, 0);
        check("R9 cap_upper_fall", cap_upper_fall, 0);
        check("R9 cap_hall", cap_hall, 0);

        // R1 R2 R3 via table
        foreach (VECS[i]) begin
            apply(VECS[i].up, VECS[i].lo, 1'b0, 1'b0, VECS[i].pos);
            snap();
            check("R1 cnt_upper_rise", cnt_upper_rise, VECS[i].e_ur);
            check("R1 cap_upper_rise", cap_upper_rise, VECS[i].e_cur);
            check("R2 cnt_upper_fall", cnt_upper_fall, VECS[i].e_uf);
            check("R2 cap_upper_fall", cap_upper_fall, VECS[i].e_cuf);
            check("R3 cnt_lower_rise", cnt_lower_rise, VECS[i].e_lr);
            check("R4 cnt_lower_fall", cnt_lower_fall, VECS[i].e_lf);
            check("R3 cap_lower_delayed", cap_lower_delayed, 0);
        end

        // R4: delay expiry on the 4th tick
        do_reset();
        apply(0, 1, 0, 0, 32'd10);
        apply(0, 0, 0, 0, 32'd50);
        for (int k = 0; k < 3; k++) tick(32'd60 + k);
        snap();
        check("R4 cnt_lower_fall", cnt_lower_fall, 1);
        check("R4 early cnt_delayed", cnt_delayed, 0);
        check("R4 early cap", cap_lower_delayed, 0);
        tick(32'd77);
        snap();
        check("R4 cnt_delayed", cnt_delayed, 1);
        check("R4 cap_lower_delayed", cap_lower_delayed, 32'd77);

        // R5: restart while pending
        do_reset();
        apply(0, 1, 0, 0, 32'd1);
        apply(0, 0, 0, 0, 32'd2);
        tick(32'd3); tick(32'd4);
        apply(0, 1, 0, 0, 32'd5);
        apply(0, 0, 0, 0, 32'd6);
        for (int k = 0; k < 3; k++) tick(32'd20 + k);
        snap();
        check("R5 no capture before restart expiry", cnt_delayed, 0);
        tick(32'd99);
        for (int k = 0; k < 6; k++) tick(32'd200 + k);
        snap();
        check("R5 single capture", cnt_delayed, 1);
        check("R5 cap value", cap_lower_delayed, 32'd99);
        check("R5 lower fall count", cnt_lower_fall, 2);

        // R6: hall falling counts, rising ignored
        do_reset();
        apply(0, 0, 1, 0, 32'd9);
        snap();
        check("R6 rising hall ignored cnt", cnt_hall, 0);
        check("R6 rising hall ignored cap", cap_hall, 0);
        apply(0, 0, 0, 0, 32'd11);
        snap();
        check("R6 hall count", cnt_hall, 1);
        check("R6 hall cap", cap_hall, 32'd11);

        // R7: wrap after 256 events
        snap();
        ur0 = cnt_upper_rise; uf0 = cnt_upper_fall;
        for (int k = 0; k < 256; k++) begin
            apply(1, 0, 0, 0, 32'd300);
            apply(0, 0, 0, 0, 32'd301);
        end
        snap();
        check("R7 rise wrap", cnt_upper_rise, ur0);
        check("R7 fall wrap", cnt_upper_fall, uf0);

        // R8: no snapshot means no output change
        do_reset();
        apply(1, 0, 0, 0, 32'd42);
        check("R8 held count", cnt_upper_rise, 0);
        check("R8 held cap", cap_upper_rise, 0);
        // R8: edge in same cycle as snapshot is not in the copy
        @(negedge clk);
        upper_in = 0; position = 32'd43; snapshot = 1'b1;
        @(negedge clk);
        snapshot = 1'b0;
        check("R8 same-cycle fall excluded", cnt_upper_fall, 0);
        check("R8 earlier rise included", cnt_upper_rise, 1);
        snap();
        check("R8 next snapshot", cnt_upper_fall, 1);
        check("R8 next snapshot cap", cap_upper_fall, 32'd43);

        // R9: reset disarms a pending delay
        apply(0, 1, 0, 0, 32'd1);
        apply(0, 0, 0, 0, 32'd2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 6; k++) tick(32'd500);
        snap();
        check("R9 pending cleared", cnt_delayed, 0);
        check("R9 count cleared", cnt_lower_fall, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule